// File: doc/BRIEF.md
# Runtime Programmable Pin Multiplexer

This block connects a set of internal functional units to a smaller set of bidirectional chip pads, with the routing chosen by software at run time. Every pad carries a select register. It can choose a fixed low level, a fixed high level, a released (high-impedance) state, or the data of any unit output. When a unit output is chosen, the pad's output enable follows that unit's own enable, so the unit itself sets the pad direction.

In the other direction, every unit input carries a select register. It can choose a fixed zero, a fixed one or the input level of any pad.

The number of unit outputs, unit inputs and pads are design-time parameters. A plain word-addressed write/read port reaches all select registers and a lock register. After software clears the lock, the whole map is frozen until the next reset. The data paths add no latency: they are combinational from the stored selects.

Top module: `pin_router`

## Requirements
- R1: After reset, the lock register reads 1, every input select reads 0, and every pad select reads 2. Every pad then has output enable 0 and every unit input is 0.
- R2: An input select of 0 drives the unit input to 0. An input select of 1 drives it to 1, whatever the pad levels are.
- R3: An input select of 2+k, with k below the pad count, drives the unit input from pad input k. This path is combinational, with no clock cycle of delay.
- R4: An input select of 2+k, with k at or above the pad count, drives the unit input to 0.
- R5: A pad select of 0 drives pad data 0 with output enable 1. A pad select of 1 drives pad data 1 with output enable 1.
- R6: A pad select of 2 gives pad output enable 0 and pad data 0.
- R7: A pad select of 3+k, with k below the unit output count, drives pad data from unit output k and pad enable from unit enable k. This path is combinational.
- R8: A pad select of 3+k, with k at or above the unit output count, gives output enable 0 and data 0, the same as code 2.
- R9: The register map is word-addressed. Address 0 is the lock register, in bit 0. Address 1+i is input select i. Address 1+NUM_SINKS+p is pad select p. A write stores the low bits of the write data, 4 bits per input select and 5 bits per pad select at the default sizes. A read returns the stored value zero-extended. A read of an unmapped address returns 0.
- R10: Writing a value with bit 0 clear to address 0 clears the lock register. Once the register is clear, a later write of 1 leaves it at 0 until reset.
- R11: While the lock register is 0, writes to the select registers are dropped. Both the stored values and the routing stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Register write strobe, sampled on the rising clock edge |
| cfg_addr | input | ADDR_W | Register word address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data, combinational from cfg_addr |
| unit_dout_i | input | NUM_SRCS | Data from the unit outputs |
| unit_doe_i | input | NUM_SRCS | Output enables from the unit outputs |
| unit_din_o | output | NUM_SINKS | Data to the unit inputs |
| pad_dout_o | output | NUM_PADS | Data to the pads |
| pad_doe_o | output | NUM_PADS | Output enables to the pads |
| pad_din_i | input | NUM_PADS | Data from the pads |

## Verification
The input path is tested with pad levels that differ between neighbouring pads and are later inverted. This shows that a routed unit input tracks the chosen pad in the same cycle, and that constant and out-of-range codes hide every pad level. The output path is tested with unit data and unit enables toggled on their own. This separates a correct data-and-enable pairing from a swapped or constant one, and shows that the released and out-of-range codes drive neither data nor enable. The last input select and the last pad select are written to check the edges of the address map. The lock is tested with a write of 1, then a write of 0, then an attempted re-arm, followed by select writes that must not change the readback or the routing. A second reset must restore all defaults.

// File: rtl/pin_router.sv
module pin_router #(
  parameter int NUM_SRCS  = 16,
  parameter int NUM_SINKS = 16,
  parameter int NUM_PADS  = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [$clog2(1+NUM_SINKS+NUM_PADS)-1:0] cfg_addr,
  input  logic [31:0]          cfg_wdata,
  output logic [31:0]          cfg_rdata,
  input  logic [NUM_SRCS-1:0]  unit_dout_i,
  input  logic [NUM_SRCS-1:0]  unit_doe_i,
  output logic [NUM_SINKS-1:0] unit_din_o,
  output logic [NUM_PADS-1:0]  pad_dout_o,
  output logic [NUM_PADS-1:0]  pad_doe_o,
  input  logic [NUM_PADS-1:0]  pad_din_i
);

  localparam int IN_SEL_W  = $clog2(NUM_PADS + 2);
  localparam int OUT_SEL_W = $clog2(NUM_SRCS + 3);
  localparam int IN_BASE   = 1;
  localparam int OUT_BASE  = 1 + NUM_SINKS;

  logic                 lock_en_q;
  logic [IN_SEL_W-1:0]  in_sel_q  [NUM_SINKS];
  logic [OUT_SEL_W-1:0] out_sel_q [NUM_PADS];

  wire unused_wdata = ^cfg_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_en_q <= 1'b1;
      for (int i = 0; i < NUM_SINKS; i++) in_sel_q[i] <= '0;
      for (int p = 0; p < NUM_PADS; p++) out_sel_q[p] <= OUT_SEL_W'(2);
    end else if (cfg_we) begin
      if (int'(cfg_addr) == 0 && !cfg_wdata[0]) lock_en_q <= 1'b0;
      if (lock_en_q) begin
        for (int i = 0; i < NUM_SINKS; i++)
          if (int'(cfg_addr) == IN_BASE + i) in_sel_q[i] <= cfg_wdata[IN_SEL_W-1:0];
        for (int p = 0; p < NUM_PADS; p++)
          if (int'(cfg_addr) == OUT_BASE + p) out_sel_q[p] <= cfg_wdata[OUT_SEL_W-1:0];
      end
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (int'(cfg_addr) == 0) cfg_rdata[0] = lock_en_q;
    for (int i = 0; i < NUM_SINKS; i++)
      if (int'(cfg_addr) == IN_BASE + i) cfg_rdata = 32'(in_sel_q[i]);
    for (int p = 0; p < NUM_PADS; p++)
      if (int'(cfg_addr) == OUT_BASE + p) cfg_rdata = 32'(out_sel_q[p]);
  end

  for (genvar gi = 0; gi < NUM_SINKS; gi++) begin : g_sink
    always_comb begin
      unit_din_o[gi] = (int'(in_sel_q[gi]) == 1);
      for (int k = 0; k < NUM_PADS; k++)
        if (int'(in_sel_q[gi]) == k + 2) unit_din_o[gi] = pad_din_i[k];
    end

    // R2
    const_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(in_sel_q[gi]) == 1) |-> unit_din_o[gi]);

    // R4
    sink_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(in_sel_q[gi]) >= NUM_PADS + 2) |-> !unit_din_o[gi]);

    // R11
    sink_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !lock_en_q |=> $stable(in_sel_q[gi]));
  end

  for (genvar gp = 0; gp < NUM_PADS; gp++) begin : g_pad
    always_comb begin
      pad_dout_o[gp] = (int'(out_sel_q[gp]) == 1);
      pad_doe_o[gp]  = (int'(out_sel_q[gp]) < 2);
      for (int k = 0; k < NUM_SRCS; k++)
        if (int'(out_sel_q[gp]) == k + 3) begin
          pad_dout_o[gp] = unit_dout_i[k];
          pad_doe_o[gp]  = unit_doe_i[k];
        end
    end

    // R6
    hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(out_sel_q[gp]) == 2) |-> (!pad_doe_o[gp] && !pad_dout_o[gp]));

    // R5
    const_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(out_sel_q[gp]) < 2) |-> pad_doe_o[gp]);

    // R8
    pad_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(out_sel_q[gp]) >= NUM_SRCS + 3) |-> (!pad_doe_o[gp] && !pad_dout_o[gp]));

    // R11
    pad_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !lock_en_q |=> $stable(out_sel_q[gp]));
  end

  // R10
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_en_q |=> !lock_en_q);

endmodule

// File: tb/pin_router_tb.sv
`timescale 1ns/1ps
module pin_router_tb;
  localparam int NS = 16, NI = 16, NP = 8;
  localparam int AW = $clog2(1 + NI + NP);
  localparam int IN_A = 1, OUT_A = 1 + NI;

  logic clk = 0, rst_n = 0, cfg_we = 0;
  logic [AW-1:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic [NS-1:0] unit_dout = '0, unit_doe = '0;
  logic [NI-1:0] unit_din;
  logic [NP-1:0] pad_dout, pad_doe, pad_din = '0;

  always #2.5 clk = ~clk;

  pin_router #(.NUM_SRCS(NS), .NUM_SINKS(NI), .NUM_PADS(NP)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .unit_dout_i(unit_dout), .unit_doe_i(unit_doe), .unit_din_o(unit_din),
    .pad_dout_o(pad_dout), .pad_doe_o(pad_doe), .pad_din_i(pad_din));

  // kind: 0 rdata, 1 pad data, 2 pad enable, 3 unit input
  typedef struct { int kind; int idx; logic [31:0] exp; string req; } item_t;
  item_t sb[$];
  int checks = 0, fails = 0;
  bit done = 0;

  task automatic expect_obs(int kind, int idx, logic [31:0] exp, string req);
    item_t it;
    it.kind = kind; it.idx = idx; it.exp = exp; it.req = req;
    sb.push_back(it);
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(int addr, logic [31:0] data);
    @(negedge clk);
    cfg_we = 1; cfg_addr = AW'(addr); cfg_wdata = data;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic rd_exp(int addr, logic [31:0] exp, string req);
    step();
    cfg_addr = AW'(addr);
    expect_obs(0, 0, exp, req);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk); #1;
      while (sb.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = sb.pop_front();
        case (it.kind)
          0: act = cfg_rdata;
          1: act = 32'(pad_dout[it.idx]);
          2: act = 32'(pad_doe[it.idx]);
          default: act = 32'(unit_din[it.idx]);
        endcase
        checks++;
        if (act !== it.exp) begin
          fails++;
          $display("FAIL %s kind=%0d idx=%0d actual=%0h expected=%0h",
                   it.req, it.kind, it.idx, act, it.exp);
        end
      end
    end
  end

  initial begin : watchdog
    #(5 * 20000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : driver
    do_reset();
    // R1 defaults
    rd_exp(0, 1, "R1");
    rd_exp(IN_A + 0, 0, "R1");
    rd_exp(OUT_A + 0, 2, "R1");
    step();
    pad_din = '1;
    for (int p = 0; p < NP; p++) expect_obs(2, p, 0, "R1");
    expect_obs(3, 0, 0, "R1");

    // R2 constants
    pad_din = 8'b1010_0101;
    wr(IN_A + 0, 1);
    wr(IN_A + 1, 0);
    step(); pad_din = '1;
    expect_obs(3, 0, 1, "R2"); expect_obs(3, 1, 0, "R2");
    step(); pad_din = '0;
    expect_obs(3, 0, 1, "R2"); expect_obs(3, 1, 0, "R2");

    // R3 routing from pad 3, same-cycle
    wr(IN_A + 2, 2 + 3);
    step(); pad_din = 8'b0000_1000;
    expect_obs(3, 2, 1, "R3");
    step(); pad_din = 8'b1111_0111;
    expect_obs(3, 2, 0, "R3");
    // R9 last input select routes from last pad
    wr(IN_A + NI - 1, 2 + NP - 1);
    step(); pad_din = 8'b1000_0000;
    expect_obs(3, NI - 1, 1, "R9");
    step(); pad_din = 8'b0111_1111;
    expect_obs(3, NI - 1, 0, "R9");

    // R4 out-of-range input code
    wr(IN_A + 3, 12);
    step(); pad_din = '1;
    expect_obs(3, 3, 0, "R4");
    rd_exp(IN_A + 3, 12, "R9");

    // R5 constant pad drive
    wr(OUT_A + 0, 0);
    wr(OUT_A + 1, 1);
    step(); unit_dout = '1; unit_doe = '0;
    expect_obs(1, 0, 0, "R5"); expect_obs(2, 0, 1, "R5");
    expect_obs(1, 1, 1, "R5"); expect_obs(2, 1, 1, "R5");

    // R7 routed pad, data and enable from unit 5
    wr(OUT_A + 2, 3 + 5);
    step(); unit_dout = 16'h0020; unit_doe = 16'h0000;
    expect_obs(1, 2, 1, "R7"); expect_obs(2, 2, 0, "R7");
    step(); unit_dout = 16'hFFDF; unit_doe = 16'h0020;
    expect_obs(1, 2, 0, "R7"); expect_obs(2, 2, 1, "R7");
    // R9 last pad select
    wr(OUT_A + NP - 1, 3 + 0);
    step(); unit_dout = 16'h0001; unit_doe = 16'h0001;
    expect_obs(1, NP - 1, 1, "R9"); expect_obs(2, NP - 1, 1, "R9");

    // R8 out-of-range pad code
    wr(OUT_A + 3, 25);
    step(); unit_dout = '1; unit_doe = '1;
    expect_obs(1, 3, 0, "R8"); expect_obs(2, 3, 0, "R8");
    rd_exp(OUT_A + 3, 25, "R9");

    // R6 released
    wr(OUT_A + 2, 2);
    step(); unit_dout = '1; unit_doe = '1;
    expect_obs(1, 2, 0, "R6"); expect_obs(2, 2, 0, "R6");

    // R9 unmapped address
    wr(30, 32'h1F);
    rd_exp(30, 0, "R9");

    // R10 lock
    wr(0, 1);
    rd_exp(0, 1, "R10");
    wr(0, 0);
    rd_exp(0, 0, "R10");
    wr(0, 1);
    rd_exp(0, 0, "R10");

    // R11 frozen map
    wr(OUT_A + 0, 1);
    wr(IN_A + 0, 0);
    rd_exp(OUT_A + 0, 0, "R11");
    rd_exp(IN_A + 0, 1, "R11");
    step();
    expect_obs(1, 0, 0, "R11"); expect_obs(2, 0, 1, "R11");
    expect_obs(3, 0, 1, "R11");

    // R1 second reset restores defaults
    do_reset();
    rd_exp(0, 1, "R1");
    rd_exp(IN_A + 0, 0, "R1");
    rd_exp(OUT_A + 1, 2, "R1");
    step();
    expect_obs(2, 1, 0, "R1");

    step(); step();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule